// File: doc/BRIEF.md
# Dual-Space MAC Operand Address Generator

This block produces the two operand fetch addresses that a multiply-accumulate style DSP instruction needs in one cycle. It holds four 16-bit pointer registers, numbered 8 to 11. Registers 8 and 9 only ever feed the X-space address port. Registers 10 and 11 only ever feed the Y-space address port. For each operand the decoder gives a register number, a 3-bit mode and a direction bit. The block drives the X and Y effective addresses combinationally. On the next clock edge it writes any post-modified pointer back into its register.

Each space has a window, given by an inclusive lower and upper bound. An address outside that window raises an out-of-range flag for the space. The block raises an error if either operand asks for a register outside its space, a reserved mode, or indexed access on a register that may not use it. An erroring instruction updates neither pointer.

A separate write port loads the pointer registers. The instruction decoder uses it to initialise the pointers and to observe them through indirect accesses.

Top module: `mac_agu`

## Requirements
- R1: After reset all four pointer registers read 0.
- R2: The X operand may select only register 8 or 9, and the Y operand only register 10 or 11. Any other select value on a valid operation raises `err_o` in the same cycle.
- R3: Mode 0 (indirect) drives the effective address equal to the selected pointer and leaves the pointer unchanged.
- R4: Modes 1, 2 and 3 (post-modify) drive the effective address equal to the selected pointer's old value. At the next edge the pointer becomes the old value plus 2, 4 or 6 respectively, or minus that step when the direction bit is 1. The arithmetic wraps modulo 2^16.
- R5: Mode 4 (indexed) drives the effective address equal to the pointer plus that space's 16-bit offset input, modulo 2^16, and leaves the pointer unchanged. Indexed mode is legal only on register 9 (X) and register 11 (Y).
- R6: Indexed mode on register 8 or 10, or mode codes 5 to 7, on a valid operation raise `err_o` in the same cycle. An erroring operation changes no pointer in either space.
- R7: Both effective addresses, `err_o` and both range flags are valid in the same cycle as `op_valid_i`. A post-modified pointer is visible from the following cycle.
- R8: On a legal valid operation, a space's out-of-range flag is 1 when its effective address, or the updated pointer in post-modify mode, lies below that space's lower bound or above its upper bound. Otherwise the flag is 0.
- R9: `wr_en_i` loads `wr_data_i` into register 8 + `wr_sel_i` at the next edge. This takes priority over a post-modify writeback to the same register in the same cycle.
- R10: With `op_valid_i` low, `err_o` and both range flags are 0 and no pointer changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Pointer load strobe |
| wr_sel_i | input | 2 | Pointer to load, 0..3 for registers 8..11 |
| wr_data_i | input | 16 | Load value |
| op_valid_i | input | 1 | Operation present this cycle |
| x_sel_i | input | 4 | X operand register number |
| x_mode_i | input | 3 | X operand mode |
| x_dec_i | input | 1 | X post-modify direction, 1 = decrement |
| y_sel_i | input | 4 | Y operand register number |
| y_mode_i | input | 3 | Y operand mode |
| y_dec_i | input | 1 | Y post-modify direction, 1 = decrement |
| x_ofs_i | input | 16 | X index offset |
| y_ofs_i | input | 16 | Y index offset |
| x_lo_i | input | 16 | X window lower bound |
| x_hi_i | input | 16 | X window upper bound |
| y_lo_i | input | 16 | Y window lower bound |
| y_hi_i | input | 16 | Y window upper bound |
| x_ea_o | output | 16 | X effective address |
| y_ea_o | output | 16 | Y effective address |
| err_o | output | 1 | Illegal selection or mode |
| x_oor_o | output | 1 | X address outside window |
| y_oor_o | output | 1 | Y address outside window |

## Verification
The effective addresses, the error and the range flags come from logic with no register in the path, so they are due in the same cycle as the stimulus. The bench drives inputs just after a falling edge and samples 1 ns later, before the next rising edge. Pointer writebacks and loads land on the next rising edge. The bench therefore reads pointers back with indirect operations only after that edge has passed, and it checks that nothing changed after illegal and idle cycles the same way.

// File: rtl/mac_agu_pkg.sv
package mac_agu_pkg;
  typedef enum logic [2:0] {
    MD_IND = 3'd0,
    MD_PM2 = 3'd1,
    MD_PM4 = 3'd2,
    MD_PM6 = 3'd3,
    MD_IDX = 3'd4
  } mode_e;

  function automatic logic [15:0] step_of(input logic [2:0] m);
    case (m)
      3'd1:    step_of = 16'd2;
      3'd2:    step_of = 16'd4;
      3'd3:    step_of = 16'd6;
      default: step_of = 16'd0;
    endcase
  endfunction
endpackage

// File: rtl/agu_lane.sv
module agu_lane
  import mac_agu_pkg::*;
#(
  parameter int AW        = 16,
  parameter int SEL_W     = 4,
  parameter int FIRST_REG = 8
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [2:0]       mode_i,
  input  logic             dec_i,
  input  logic [AW-1:0]    ptr_a_i,
  input  logic [AW-1:0]    ptr_b_i,
  input  logic [AW-1:0]    ofs_i,
  input  logic [AW-1:0]    win_lo_i,
  input  logic [AW-1:0]    win_hi_i,
  output logic [AW-1:0]    ea_o,
  output logic [AW-1:0]    nxt_o,
  output logic             upd_o,
  output logic             slot_o,
  output logic             legal_o,
  output logic             oor_o
);
  localparam logic [SEL_W-1:0] REG_A = SEL_W'(FIRST_REG);
  localparam logic [SEL_W-1:0] REG_B = SEL_W'(FIRST_REG + 1);

  logic          hit;
  logic [AW-1:0] ptr;
  logic [AW-1:0] step;
  logic          ea_out, nxt_out;

  assign hit    = (sel_i == REG_A) || (sel_i == REG_B);
  assign slot_o = (sel_i == REG_B);
  assign ptr    = slot_o ? ptr_b_i : ptr_a_i;
  assign step   = AW'(step_of(mode_i));

  always_comb begin
    ea_o    = ptr;
    nxt_o   = ptr;
    upd_o   = 1'b0;
    legal_o = hit;
    case (mode_i)
      MD_IND: ;
      MD_PM2, MD_PM4, MD_PM6: begin
        nxt_o = dec_i ? (ptr - step) : (ptr + step);
        upd_o = hit;
      end
      MD_IDX: begin
        ea_o    = ptr + ofs_i;
        legal_o = hit && slot_o;  // indexed only on the second register of the pair
      end
      default: legal_o = 1'b0;
    endcase
  end

  assign ea_out  = (ea_o < win_lo_i) || (ea_o > win_hi_i);
  assign nxt_out = upd_o && ((nxt_o < win_lo_i) || (nxt_o > win_hi_i));
  assign oor_o   = ea_out || nxt_out;
endmodule

// File: rtl/agu_ptr_file.sv
module agu_ptr_file #(
  parameter int AW   = 16,
  parameter int NPTR = 4,
  localparam int IW  = $clog2(NPTR)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [IW-1:0]             wr_idx_i,
  input  logic [AW-1:0]             wr_data_i,
  input  logic                      x_upd_i,
  input  logic [IW-1:0]             x_idx_i,
  input  logic [AW-1:0]             x_nxt_i,
  input  logic                      y_upd_i,
  input  logic [IW-1:0]             y_idx_i,
  input  logic [AW-1:0]             y_nxt_i,
  output logic [NPTR-1:0][AW-1:0]   ptr_o
);
  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    localparam logic [IW-1:0] ME = IW'(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        ptr_o[g] <= '0;
      else if (wr_en_i && wr_idx_i == ME) ptr_o[g] <= wr_data_i;
      else if (x_upd_i && x_idx_i == ME)  ptr_o[g] <= x_nxt_i;
      else if (y_upd_i && y_idx_i == ME)  ptr_o[g] <= y_nxt_i;
    end
  end
endmodule

// File: rtl/mac_agu.sv
module mac_agu #(
  parameter int AW     = 16,
  parameter int SEL_W  = 4,
  parameter int X_REG0 = 8,
  parameter int Y_REG0 = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [AW-1:0]    wr_data_i,
  input  logic             op_valid_i,
  input  logic [SEL_W-1:0] x_sel_i,
  input  logic [2:0]       x_mode_i,
  input  logic             x_dec_i,
  input  logic [SEL_W-1:0] y_sel_i,
  input  logic [2:0]       y_mode_i,
  input  logic             y_dec_i,
  input  logic [AW-1:0]    x_ofs_i,
  input  logic [AW-1:0]    y_ofs_i,
  input  logic [AW-1:0]    x_lo_i,
  input  logic [AW-1:0]    x_hi_i,
  input  logic [AW-1:0]    y_lo_i,
  input  logic [AW-1:0]    y_hi_i,
  output logic [AW-1:0]    x_ea_o,
  output logic [AW-1:0]    y_ea_o,
  output logic             err_o,
  output logic             x_oor_o,
  output logic             y_oor_o
);
  localparam int NPTR = 4;
  localparam int IW   = $clog2(NPTR);

  logic [NPTR-1:0][AW-1:0] ptr_q;
  logic [AW-1:0] x_nxt, y_nxt;
  logic x_upd, y_upd, x_slot, y_slot, x_legal, y_legal, x_oor, y_oor;
  logic commit;

  agu_lane #(.AW(AW), .SEL_W(SEL_W), .FIRST_REG(X_REG0)) u_x_lane (
    .sel_i(x_sel_i), .mode_i(x_mode_i), .dec_i(x_dec_i),
    .ptr_a_i(ptr_q[0]), .ptr_b_i(ptr_q[1]), .ofs_i(x_ofs_i),
    .win_lo_i(x_lo_i), .win_hi_i(x_hi_i),
    .ea_o(x_ea_o), .nxt_o(x_nxt), .upd_o(x_upd), .slot_o(x_slot),
    .legal_o(x_legal), .oor_o(x_oor)
  );

  agu_lane #(.AW(AW), .SEL_W(SEL_W), .FIRST_REG(Y_REG0)) u_y_lane (
    .sel_i(y_sel_i), .mode_i(y_mode_i), .dec_i(y_dec_i),
    .ptr_a_i(ptr_q[2]), .ptr_b_i(ptr_q[3]), .ofs_i(y_ofs_i),
    .win_lo_i(y_lo_i), .win_hi_i(y_hi_i),
    .ea_o(y_ea_o), .nxt_o(y_nxt), .upd_o(y_upd), .slot_o(y_slot),
    .legal_o(y_legal), .oor_o(y_oor)
  );

  // both operands must be legal before either pointer moves
  assign commit  = op_valid_i && x_legal && y_legal;
  assign err_o   = op_valid_i && !(x_legal && y_legal);
  assign x_oor_o = commit && x_oor;
  assign y_oor_o = commit && y_oor;

  agu_ptr_file #(.AW(AW), .NPTR(NPTR)) u_ptrs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_idx_i(wr_sel_i), .wr_data_i(wr_data_i),
    .x_upd_i(commit && x_upd), .x_idx_i({1'b0, x_slot}), .x_nxt_i(x_nxt),
    .y_upd_i(commit && y_upd), .y_idx_i({1'b1, y_slot}), .y_nxt_i(y_nxt),
    .ptr_o(ptr_q)
  );

  logic [IW-1:0] unused_iw;
  assign unused_iw = '0;
endmodule

// File: rtl/mac_agu_checker.sv
module mac_agu_checker #(
  parameter int AW    = 16,
  parameter int SEL_W = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wr_en_i,
  input logic [1:0]           wr_sel_i,
  input logic [AW-1:0]        wr_data_i,
  input logic                 op_valid_i,
  input logic [SEL_W-1:0]     x_sel_i,
  input logic [2:0]           x_mode_i,
  input logic                 x_dec_i,
  input logic [2:0]           y_mode_i,
  input logic [AW-1:0]        x_lo_i,
  input logic [AW-1:0]        x_hi_i,
  input logic [AW-1:0]        x_ea_o,
  input logic                 err_o,
  input logic                 x_oor_o,
  input logic                 y_oor_o,
  input logic [3:0][AW-1:0]   ptr_q
);
  assert_x_binding_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && x_sel_i != SEL_W'(8) && x_sel_i != SEL_W'(9) |-> err_o);

  assert_indirect_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && !err_o && x_mode_i == 3'd0 && y_mode_i == 3'd0 && !wr_en_i
    |=> $stable(ptr_q));

  assert_pm2_inc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && !err_o && x_mode_i == 3'd1 && !x_dec_i && !wr_en_i
    |=> ptr_q[$past(x_sel_i[0])] == $past(x_ea_o) + AW'(2));

  assert_error_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && err_o && !wr_en_i |=> $stable(ptr_q));

  assert_x_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && !err_o && (x_ea_o < x_lo_i || x_ea_o > x_hi_i) |-> x_oor_o);

  assert_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ptr_q[$past(wr_sel_i)] == $past(wr_data_i));

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |-> !err_o && !x_oor_o && !y_oor_o);

  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i && !wr_en_i |=> $stable(ptr_q));
endmodule

bind mac_agu mac_agu_checker #(.AW(AW), .SEL_W(SEL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
  .wr_data_i(wr_data_i), .op_valid_i(op_valid_i), .x_sel_i(x_sel_i),
  .x_mode_i(x_mode_i), .x_dec_i(x_dec_i), .y_mode_i(y_mode_i),
  .x_lo_i(x_lo_i), .x_hi_i(x_hi_i), .x_ea_o(x_ea_o), .err_o(err_o),
  .x_oor_o(x_oor_o), .y_oor_o(y_oor_o), .ptr_q(ptr_q)
);

// File: tb/mac_agu_test.sv
`timescale 1ns/1ps
module mac_agu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        op_valid = 1'b0;
  logic [3:0]  x_sel = 4'd8, y_sel = 4'd10;
  logic [2:0]  x_mode = '0, y_mode = '0;
  logic        x_dec = 1'b0, y_dec = 1'b0;
  logic [15:0] x_ofs = '0, y_ofs = '0;
  logic [15:0] x_lo = 16'h0800, x_hi = 16'h17FF, y_lo = 16'h1800, y_hi = 16'h27FF;
  logic [15:0] x_ea, y_ea;
  logic        err, x_oor, y_oor;
  int          n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  mac_agu uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .op_valid_i(op_valid), .x_sel_i(x_sel),
    .x_mode_i(x_mode), .x_dec_i(x_dec), .y_sel_i(y_sel), .y_mode_i(y_mode),
    .y_dec_i(y_dec), .x_ofs_i(x_ofs), .y_ofs_i(y_ofs), .x_lo_i(x_lo),
    .x_hi_i(x_hi), .y_lo_i(y_lo), .y_hi_i(y_hi), .x_ea_o(x_ea), .y_ea_o(y_ea),
    .err_o(err), .x_oor_o(x_oor), .y_oor_o(y_oor)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // indirect read of one X and one Y pointer, no edge crossed
  task automatic peek(input logic [3:0] xs, input logic [3:0] ys,
                      input logic [15:0] ex, input logic [15:0] ey, input string req);
    @(negedge clk);
    x_sel = xs; y_sel = ys; x_mode = 3'd0; y_mode = 3'd0; op_valid = 1'b1;
    #1;
    chk(req, x_ea, ex);
    chk(req, y_ea, ey);
    op_valid = 1'b0;
  endtask

  task automatic load(input logic [1:0] s, input logic [15:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // drive an op, check same-cycle outputs, cross one rising edge
  task automatic op(input logic [3:0] xs, input logic [2:0] xm, input logic xd,
                    input logic [3:0] ys, input logic [2:0] ym, input logic yd,
                    input logic [15:0] ex, input logic [15:0] ey,
                    input logic e_err, input logic e_xo, input logic e_yo,
                    input string req);
    @(negedge clk);
    x_sel = xs; x_mode = xm; x_dec = xd; y_sel = ys; y_mode = ym; y_dec = yd;
    op_valid = 1'b1;
    #1;
    if (!e_err) begin
      chk({req, " x_ea"}, x_ea, ex);
      chk({req, " y_ea"}, y_ea, ey);
    end
    chk({req, " err"}, {15'd0, err}, {15'd0, e_err});
    chk({req, " x_oor"}, {15'd0, x_oor}, {15'd0, e_xo});
    chk({req, " y_oor"}, {15'd0, y_oor}, {15'd0, e_yo});
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic t_reset;
    peek(4'd8, 4'd10, 16'h0000, 16'h0000, "R1 reset");
    peek(4'd9, 4'd11, 16'h0000, 16'h0000, "R1 reset");
  endtask

  task automatic t_load;
    load(2'd0, 16'h1000); load(2'd1, 16'h1100);
    load(2'd2, 16'h2000); load(2'd3, 16'h2100);
    peek(4'd8, 4'd10, 16'h1000, 16'h2000, "R9 load");
    peek(4'd9, 4'd11, 16'h1100, 16'h2100, "R9 load");
  endtask

  task automatic t_indirect;
    op(4'd9, 3'd0, 1'b0, 4'd11, 3'd0, 1'b0, 16'h1100, 16'h2100, 0, 0, 0, "R3 R7 indirect");
    peek(4'd9, 4'd11, 16'h1100, 16'h2100, "R3 no update");
  endtask

  task automatic t_postmod;
    op(4'd8, 3'd2, 1'b0, 4'd10, 3'd3, 1'b1, 16'h1000, 16'h2000, 0, 0, 0, "R4 R7 pm4+/pm6-");
    peek(4'd8, 4'd10, 16'h1004, 16'h1FFA, "R4 writeback");
    op(4'd9, 3'd1, 1'b1, 4'd11, 3'd1, 1'b0, 16'h1100, 16'h2100, 0, 0, 0, "R4 pm2-/pm2+");
    peek(4'd9, 4'd11, 16'h10FE, 16'h2102, "R4 writeback");
  endtask

  task automatic t_indexed;
    @(negedge clk);
    x_ofs = 16'h0010; y_ofs = 16'hFFF0;
    op(4'd9, 3'd4, 1'b0, 4'd11, 3'd4, 1'b0, 16'h110E, 16'h20F2, 0, 0, 0, "R5 indexed");
    peek(4'd9, 4'd11, 16'h10FE, 16'h2102, "R5 no update");
  endtask

  task automatic t_illegal;
    op(4'd8, 3'd4, 1'b0, 4'd10, 3'd1, 1'b0, 16'h0, 16'h0, 1, 0, 0, "R6 idx on 8");
    peek(4'd8, 4'd10, 16'h1004, 16'h1FFA, "R6 hold");
    op(4'd9, 3'd1, 1'b0, 4'd10, 3'd4, 1'b0, 16'h0, 16'h0, 1, 0, 0, "R6 idx on 10");
    op(4'd10, 3'd0, 1'b0, 4'd11, 3'd1, 1'b0, 16'h0, 16'h0, 1, 0, 0, "R2 Y reg on X");
    op(4'd9, 3'd2, 1'b0, 4'd12, 3'd0, 1'b0, 16'h0, 16'h0, 1, 0, 0, "R2 reg 12 on Y");
    op(4'd8, 3'd1, 1'b0, 4'd11, 3'd5, 1'b0, 16'h0, 16'h0, 1, 0, 0, "R6 mode 5");
    op(4'd8, 3'd7, 1'b0, 4'd11, 3'd1, 1'b0, 16'h0, 16'h0, 1, 0, 0, "R6 mode 7");
    peek(4'd8, 4'd10, 16'h1004, 16'h1FFA, "R6 hold");
    peek(4'd9, 4'd11, 16'h10FE, 16'h2102, "R6 hold");
  endtask

  task automatic t_range;
    load(2'd0, 16'h17FE);
    op(4'd8, 3'd2, 1'b0, 4'd10, 3'd0, 1'b0, 16'h17FE, 16'h1FFA, 0, 1, 0, "R8 post addr out");
    op(4'd8, 3'd0, 1'b0, 4'd10, 3'd0, 1'b0, 16'h1802, 16'h1FFA, 0, 1, 0, "R8 ea above hi");
    @(negedge clk);
    y_ofs = 16'h1000;
    op(4'd9, 3'd0, 1'b0, 4'd11, 3'd4, 1'b0, 16'h10FE, 16'h3102, 0, 0, 1, "R8 y idx out");
    load(2'd2, 16'h1800);
    op(4'd9, 3'd0, 1'b0, 4'd10, 3'd1, 1'b1, 16'h10FE, 16'h1800, 0, 0, 1, "R8 y dec below lo");
    peek(4'd8, 4'd10, 16'h1802, 16'h17FE, "R4 R8 writeback");
    load(2'd2, 16'h1800);
    op(4'd9, 3'd0, 1'b0, 4'd10, 3'd0, 1'b0, 16'h10FE, 16'h1800, 0, 0, 0, "R8 at lo bound");
  endtask

  task automatic t_wrap;
    load(2'd1, 16'h0002);
    op(4'd9, 3'd3, 1'b1, 4'd10, 3'd0, 1'b0, 16'h0002, 16'h1800, 0, 1, 0, "R4 wrap");
    peek(4'd9, 4'd10, 16'hFFFC, 16'h1800, "R4 wrap value");
    load(2'd1, 16'h10FE);
  endtask

  task automatic t_idle;
    @(negedge clk);
    x_sel = 4'd8; x_mode = 3'd3; y_sel = 4'd13; y_mode = 3'd6; op_valid = 1'b0;
    #1;
    chk("R10 idle err", {15'd0, err}, 16'd0);
    chk("R10 idle x_oor", {15'd0, x_oor}, 16'd0);
    chk("R10 idle y_oor", {15'd0, y_oor}, 16'd0);
    @(negedge clk);
    peek(4'd8, 4'd10, 16'h1802, 16'h1800, "R10 hold");
  endtask

  task automatic t_wr_prio;
    @(negedge clk);
    x_sel = 4'd9; x_mode = 3'd1; x_dec = 1'b0;
    y_sel = 4'd11; y_mode = 3'd1; y_dec = 1'b0; op_valid = 1'b1;
    wr_en = 1'b1; wr_sel = 2'd1; wr_data = 16'h0ABC;
    @(negedge clk);
    op_valid = 1'b0; wr_en = 1'b0;
    peek(4'd9, 4'd11, 16'h0ABC, 16'h2104, "R9 write priority");
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load();
    t_indirect();
    t_postmod();
    t_indexed();
    t_illegal();
    t_range();
    t_wrap();
    t_idle();
    t_wr_prio();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule